// File: doc/BRIEF.md
# Ping-Pong Pseudo-DMA Host Buffer

This block sits between a SCSI protocol core, seen here as a byte-wide valid/ready stream, and a host that moves data through a single I/O data port. Two 128-byte buffers alternate. While one side fills a buffer, the other side can drain the second one. The host therefore moves whole blocks with plain port accesses while the core keeps streaming.

Before a transfer, the host writes a direction through the control port. A one selects receive, which moves data from SCSI to the host. A zero selects send. The host then loads a count of 128-byte blocks. A non-zero count starts the transfer. The status outputs report three things: whether a buffer is available to the host, the core interrupt gated by transfer activity, and whether the core's own registers may be touched. A sticky end-of-transfer flag rises once the last block has reached its destination. An abort written through the control port drops everything and returns the logic to idle.

Top module: `pdma_pingpong`

## Requirements
- R1: After reset, `st_core_acc`=1, `st_not_rdy`=1, `blk_cnt`=0, `xfer_done`=0, `rx_ready`=0 and `tx_valid`=0.
- R2: A `cnt_wr` with a non-zero value starts a transfer. From the next cycle, `st_core_acc`=0, `xfer_done`=0 and `blk_cnt` reads the loaded value.
- R3: In receive mode (`ctl_dir`=1), successive `hp_rd` accesses return the bytes accepted on the rx stream in arrival order. With a 16-bit port, the earlier byte is in bits 7:0. A block takes 128/(PORT_W/8) port accesses.
- R4: In receive mode, `st_not_rdy` stays 1 until a buffer holds all 128 bytes.
- R5: The core may fill the second buffer while the first waits for the host. `rx_ready` is 0 while both buffers are full, and it returns to 1 once the host has drained one of them.
- R6: `blk_cnt` decrements by one each time the consuming side finishes a block. In receive mode the consumer is the host; in send mode it is the core.
- R7: When `blk_cnt` reaches 0, the transfer ends: `xfer_done`=1, `st_core_acc`=1 and `st_not_rdy`=1.
- R8: `st_gated_irq` follows `core_irq` while a transfer is active and is 0 otherwise.
- R9: In send mode (`ctl_dir`=0), host writes are emitted on the tx stream in order, with the low byte first. `st_not_rdy` is 1 when no empty buffer is free or when all loaded blocks have already been written.
- R10: An `hp_rd` while `st_not_rdy`=1 does not advance the read position. The next valid read returns the first byte of the block.
- R11: A control write with `ctl_abort`=1 returns the logic to idle in the next cycle: `st_core_acc`=1, `blk_cnt`=0, `xfer_done`=0, `rx_ready`=0 and `st_not_rdy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_dir | input | 1 | Direction written with `ctl_wr` (1 = receive) |
| ctl_abort | input | 1 | Abort bit written with `ctl_wr` |
| cnt_wr | input | 1 | Block-count load strobe |
| cnt_wdata | input | CNT_W | Number of 128-byte blocks |
| hp_rd | input | 1 | Host data port read strobe |
| hp_wr | input | 1 | Host data port write strobe |
| hp_wdata | input | PORT_W | Host write data |
| hp_rdata | output | PORT_W | Host read data |
| rx_valid | input | 1 | Core byte valid (receive) |
| rx_data | input | 8 | Core byte (receive) |
| rx_ready | output | 1 | Block accepts a core byte |
| tx_valid | output | 1 | Byte offered to the core (send) |
| tx_data | output | 8 | Byte offered to the core |
| tx_ready | input | 1 | Core takes the byte |
| core_irq | input | 1 | Raw core interrupt |
| st_not_rdy | output | 1 | No buffer is available to the host |
| st_gated_irq | output | 1 | Core interrupt gated by transfer activity |
| st_core_acc | output | 1 | Core registers may be accessed |
| blk_cnt | output | CNT_W | Blocks remaining |
| xfer_done | output | 1 | Sticky end-of-transfer flag |

## Verification
The receive path is run with three blocks. The second block is streamed in before the host reads the first, which separates true ping-pong operation from a single-buffer design: `rx_ready` must fall with both buffers full and rise after one drain. Reads issued before any buffer is full show whether the read position slips. A distinct byte pattern on every byte exposes lane swaps in the 16-bit port. The send path fills both buffers while the core is stalled and then releases the core, which shows both the not-ready rule once no block is left to write and the core-side count decrement. An abort in the middle of a block shows that the logic returns to idle without a completion flag.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    parameter int unsigned PDMA_BLK_BYTES = 128;

    typedef enum logic {
        DIR_SEND = 1'b0,
        DIR_RECV = 1'b1
    } pdma_dir_e;
endpackage

// File: rtl/pdma_bufmem.sv
module pdma_bufmem #(
    parameter int unsigned PORT_W    = 8,
    parameter int unsigned BLK_BYTES = 128,
    localparam int unsigned LANES    = PORT_W / 8,
    localparam int unsigned WPB      = BLK_BYTES / LANES,
    localparam int unsigned BA_W     = $clog2(2 * BLK_BYTES),
    localparam int unsigned HA_W     = $clog2(2 * WPB)
) (
    input  logic              clk,
    input  logic              c_we,
    input  logic [BA_W-1:0]   c_addr,
    input  logic [7:0]        c_wdata,
    output logic [7:0]        c_rdata,
    input  logic              h_we,
    input  logic [HA_W-1:0]   h_addr,
    input  logic [PORT_W-1:0] h_wdata,
    output logic [PORT_W-1:0] h_rdata
);
    logic [7:0] mem_q [2*BLK_BYTES];

    // Core and host never address the same buffer in one cycle.
    always_ff @(posedge clk) begin
        if (c_we) mem_q[c_addr] <= c_wdata;
        if (h_we) begin
            for (int l = 0; l < int'(LANES); l++) begin
                mem_q[BA_W'(int'(h_addr) * int'(LANES) + l)] <= h_wdata[l*8 +: 8];
            end
        end
    end

    assign c_rdata = mem_q[c_addr];

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        assign h_rdata[g*8 +: 8] = mem_q[BA_W'(int'(h_addr) * int'(LANES) + g)];
    end
endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
    import pdma_pkg::*;
#(
    parameter int unsigned PORT_W    = 8,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned BLK_BYTES = 128,
    localparam int unsigned LANES    = PORT_W / 8,
    localparam int unsigned WPB      = BLK_BYTES / LANES,
    localparam int unsigned HP_W     = $clog2(WPB),
    localparam int unsigned CP_W     = $clog2(BLK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_dir,
    input  logic             ctl_abort,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             hp_rd,
    input  logic             hp_wr,
    input  logic             rx_valid,
    input  logic             tx_ready,
    input  logic             core_irq,
    output logic             rx_ready,
    output logic             tx_valid,
    output logic             st_not_rdy,
    output logic             st_gated_irq,
    output logic             st_core_acc,
    output logic [CNT_W-1:0] blk_cnt,
    output logic             xfer_done,
    output logic             c_we,
    output logic [CP_W:0]    c_addr,
    output logic             h_we,
    output logic [HP_W:0]    h_addr
);
    typedef struct packed {
        logic            active;
        logic            dir;
        logic            done;
        logic [CNT_W-1:0] blk_cnt;
        logic [CNT_W-1:0] prod_left;
        logic [1:0]      full;
        logic            hsel;
        logic [HP_W-1:0] hptr;
        logic            csel;
        logic [CP_W-1:0] cptr;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;
    logic recv, host_rdy, rx_ok, tx_ok, h_go, c_go;

    always_comb begin
        s_d      = s_q;
        recv     = (s_q.dir == DIR_RECV);
        host_rdy = s_q.active && (recv ? s_q.full[s_q.hsel]
                                       : (!s_q.full[s_q.hsel] && s_q.prod_left != '0));
        rx_ok    = s_q.active && recv && !s_q.full[s_q.csel] && s_q.prod_left != '0;
        tx_ok    = s_q.active && !recv && s_q.full[s_q.csel];
        h_go     = host_rdy && (recv ? hp_rd : hp_wr);
        c_go     = (rx_ok && rx_valid) || (tx_ok && tx_ready);

        // host side: consumer on receive, producer on send
        if (h_go) begin
            if (s_q.hptr == HP_W'(WPB - 1)) begin
                s_d.hptr = '0;
                s_d.hsel = !s_q.hsel;
                if (recv) begin
                    s_d.full[s_q.hsel] = 1'b0;
                    s_d.blk_cnt        = s_q.blk_cnt - 1'b1;
                end else begin
                    s_d.full[s_q.hsel] = 1'b1;
                    s_d.prod_left      = s_q.prod_left - 1'b1;
                end
            end else begin
                s_d.hptr = s_q.hptr + 1'b1;
            end
        end

        // core side: producer on receive, consumer on send
        if (c_go) begin
            if (s_q.cptr == CP_W'(BLK_BYTES - 1)) begin
                s_d.cptr = '0;
                s_d.csel = !s_q.csel;
                if (recv) begin
                    s_d.full[s_q.csel] = 1'b1;
                    s_d.prod_left      = s_q.prod_left - 1'b1;
                end else begin
                    s_d.full[s_q.csel] = 1'b0;
                    s_d.blk_cnt        = s_q.blk_cnt - 1'b1;
                end
            end else begin
                s_d.cptr = s_q.cptr + 1'b1;
            end
        end

        if (s_q.active && s_d.blk_cnt == '0) begin
            s_d.active = 1'b0;
            s_d.done   = 1'b1;
        end

        if (cnt_wr) begin
            s_d.blk_cnt   = cnt_wdata;
            s_d.prod_left = cnt_wdata;
            s_d.full      = '0;
            s_d.hsel      = 1'b0;
            s_d.hptr      = '0;
            s_d.csel      = 1'b0;
            s_d.cptr      = '0;
            s_d.active    = (cnt_wdata != '0);
            s_d.done      = 1'b0;
        end

        if (ctl_wr) begin
            if (ctl_abort)       s_d = '0;
            else if (!s_q.active) s_d.dir = ctl_dir;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_ready     = rx_ok;
    assign tx_valid     = tx_ok;
    assign st_not_rdy   = !host_rdy;
    assign st_gated_irq = s_q.active && core_irq;
    assign st_core_acc  = !s_q.active;
    assign blk_cnt      = s_q.blk_cnt;
    assign xfer_done    = s_q.done;
    assign c_we         = rx_ok && rx_valid;
    assign c_addr       = {s_q.csel, s_q.cptr};
    assign h_we         = host_rdy && !recv && hp_wr;
    assign h_addr       = {s_q.hsel, s_q.hptr};
endmodule

// File: rtl/pdma_pingpong.sv
module pdma_pingpong
    import pdma_pkg::*;
#(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned CNT_W  = 8,
    localparam int unsigned LANES = PORT_W / 8,
    localparam int unsigned WPB   = PDMA_BLK_BYTES / LANES,
    localparam int unsigned HP_W  = $clog2(WPB),
    localparam int unsigned CP_W  = $clog2(PDMA_BLK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_dir,
    input  logic              ctl_abort,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              hp_rd,
    input  logic              hp_wr,
    input  logic [PORT_W-1:0] hp_wdata,
    output logic [PORT_W-1:0] hp_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              core_irq,
    output logic              st_not_rdy,
    output logic              st_gated_irq,
    output logic              st_core_acc,
    output logic [CNT_W-1:0]  blk_cnt,
    output logic              xfer_done
);
    logic            c_we, h_we;
    logic [CP_W:0]   c_addr;
    logic [HP_W:0]   h_addr;

    pdma_ctrl #(
        .PORT_W(PORT_W), .CNT_W(CNT_W), .BLK_BYTES(PDMA_BLK_BYTES)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_dir(ctl_dir), .ctl_abort(ctl_abort),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .hp_rd(hp_rd), .hp_wr(hp_wr),
        .rx_valid(rx_valid), .tx_ready(tx_ready), .core_irq(core_irq),
        .rx_ready(rx_ready), .tx_valid(tx_valid),
        .st_not_rdy(st_not_rdy), .st_gated_irq(st_gated_irq),
        .st_core_acc(st_core_acc), .blk_cnt(blk_cnt), .xfer_done(xfer_done),
        .c_we(c_we), .c_addr(c_addr), .h_we(h_we), .h_addr(h_addr)
    );

    pdma_bufmem #(
        .PORT_W(PORT_W), .BLK_BYTES(PDMA_BLK_BYTES)
    ) mem_i (
        .clk(clk),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(rx_data), .c_rdata(tx_data),
        .h_we(h_we), .h_addr(h_addr), .h_wdata(hp_wdata), .h_rdata(hp_rdata)
    );
endmodule

// File: rtl/pdma_pingpong_chk.sv
module pdma_pingpong_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             ctl_abort,
    input logic             cnt_wr,
    input logic             rx_ready,
    input logic             tx_valid,
    input logic             st_gated_irq,
    input logic             st_core_acc,
    input logic [CNT_W-1:0] blk_cnt,
    input logic             xfer_done
);
    assert_idle_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_core_acc |-> !st_gated_irq);

    assert_idle_stream_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_core_acc |-> (!rx_ready && !tx_valid));

    assert_count_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> blk_cnt <= $past(blk_cnt));

    assert_done_means_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (blk_cnt == '0 && st_core_acc));

    assert_abort_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_abort) |=> (st_core_acc && !xfer_done && blk_cnt == '0));
endmodule

bind pdma_pingpong pdma_pingpong_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_abort(ctl_abort),
    .cnt_wr(cnt_wr), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .st_gated_irq(st_gated_irq), .st_core_acc(st_core_acc),
    .blk_cnt(blk_cnt), .xfer_done(xfer_done)
);

// File: tb/pdma_pingpong_tb_top.sv
module pdma_pingpong_tb_top;
    localparam int PW = 16;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, ctl_dir = 0, ctl_abort = 0, cnt_wr = 0;
    logic [CW-1:0] cnt_wdata = '0;
    logic hp_rd = 0, hp_wr = 0;
    logic [PW-1:0] hp_wdata = '0;
    logic [PW-1:0] hp_rdata;
    logic rx_valid = 0;
    logic [7:0] rx_data = '0;
    logic rx_ready, tx_valid, tx_ready = 0, core_irq = 0;
    logic [7:0] tx_data;
    logic st_not_rdy, st_gated_irq, st_core_acc, xfer_done;
    logic [CW-1:0] blk_cnt;

    always #4 clk = !clk;

    pdma_pingpong #(.PORT_W(PW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_dir(ctl_dir),
        .ctl_abort(ctl_abort), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .hp_rd(hp_rd), .hp_wr(hp_wr), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .core_irq(core_irq), .st_not_rdy(st_not_rdy), .st_gated_irq(st_gated_irq),
        .st_core_acc(st_core_acc), .blk_cnt(blk_cnt), .xfer_done(xfer_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    logic [7:0] pat = 8'h5a;

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ctl_write(logic dir, logic abort);
        @(negedge clk);
        ctl_wr = 1; ctl_dir = dir; ctl_abort = abort;
        @(posedge clk); #1;
        ctl_wr = 0; ctl_abort = 0;
    endtask

    task automatic cnt_load(logic [CW-1:0] n);
        @(negedge clk);
        cnt_wr = 1; cnt_wdata = n;
        @(posedge clk); #1;
        cnt_wr = 0;
    endtask

    // driver: core byte, pushed to the scoreboard when accepted
    task automatic rx_byte();
        @(negedge clk);
        rx_valid = 1; rx_data = pat;
        while (!rx_ready) @(negedge clk);
        @(posedge clk); #1;
        exp_q.push_back(pat);
        pat = pat + 8'd37;
        rx_valid = 0;
    endtask

    task automatic rx_bytes(int n);
        for (int i = 0; i < n; i++) rx_byte();
    endtask

    // monitor for the receive side: host read compared with the scoreboard
    task automatic host_read(string req);
        logic [PW-1:0] w;
        logic nr;
        logic [7:0] lo, hi;
        @(negedge clk);
        w = hp_rdata; nr = st_not_rdy;
        hp_rd = 1;
        @(posedge clk); #1;
        hp_rd = 0;
        chk(req, "not_rdy at read", longint'(nr), 0);
        lo = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        hi = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        chk(req, "read word", longint'(w), longint'({hi, lo}));
    endtask

    task automatic host_write();
        @(negedge clk);
        hp_wr = 1; hp_wdata = {pat + 8'd37, pat};
        @(posedge clk); #1;
        hp_wr = 0;
        exp_q.push_back(pat);
        exp_q.push_back(pat + 8'd37);
        pat = pat + 8'd74;
    endtask

    // monitor for the send side
    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) chk("R9", "tx byte with empty scoreboard", 1, 0);
            else chk("R9", "tx byte", longint'(tx_data), longint'(exp_q.pop_front()));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "core_acc", longint'(st_core_acc), 1);
        chk("R1", "not_rdy", longint'(st_not_rdy), 1);
        chk("R1", "blk_cnt", longint'(blk_cnt), 0);
        chk("R1", "done", longint'(xfer_done), 0);
        chk("R1", "rx_ready/tx_valid", longint'({rx_ready, tx_valid}), 0);

        // receive, three blocks
        ctl_write(1'b1, 1'b0);
        cnt_load(8'd3);
        @(negedge clk);
        chk("R2", "core_acc", longint'(st_core_acc), 0);
        chk("R2", "blk_cnt", longint'(blk_cnt), 3);
        chk("R4", "not_rdy before data", longint'(st_not_rdy), 1);
        core_irq = 1;
        #1 chk("R8", "gated irq active", longint'(st_gated_irq), 1);
        core_irq = 0;

        // R10: reads while not ready must not move the position
        @(negedge clk); hp_rd = 1;
        repeat (2) @(posedge clk);
        #1 hp_rd = 0;

        rx_bytes(127);
        @(negedge clk);
        chk("R4", "not_rdy at 127 bytes", longint'(st_not_rdy), 1);
        rx_bytes(1);
        @(negedge clk);
        chk("R4", "not_rdy at 128 bytes", longint'(st_not_rdy), 0);
        rx_bytes(128);
        @(negedge clk);
        chk("R5", "rx_ready both full", longint'(rx_ready), 0);

        host_read("R10");
        for (int i = 1; i < 64; i++) host_read("R3");
        @(negedge clk);
        chk("R6", "blk_cnt after drain 1", longint'(blk_cnt), 2);
        chk("R5", "rx_ready after drain", longint'(rx_ready), 1);

        rx_bytes(128);
        for (int i = 0; i < 64; i++) host_read("R3");
        @(negedge clk);
        chk("R6", "blk_cnt after drain 2", longint'(blk_cnt), 1);
        for (int i = 0; i < 64; i++) host_read("R3");
        @(negedge clk);
        chk("R7", "done", longint'(xfer_done), 1);
        chk("R7", "core_acc", longint'(st_core_acc), 1);
        chk("R7", "not_rdy", longint'(st_not_rdy), 1);
        chk("R6", "blk_cnt end", longint'(blk_cnt), 0);
        core_irq = 1;
        #1 chk("R8", "gated irq idle", longint'(st_gated_irq), 0);
        core_irq = 0;

        // send, two blocks
        ctl_write(1'b0, 1'b0);
        cnt_load(8'd2);
        @(negedge clk);
        chk("R2", "done cleared", longint'(xfer_done), 0);
        chk("R9", "not_rdy empty buffer", longint'(st_not_rdy), 0);
        for (int i = 0; i < 64; i++) host_write();
        @(negedge clk);
        chk("R9", "not_rdy second free", longint'(st_not_rdy), 0);
        chk("R9", "tx_valid", longint'(tx_valid), 1);
        for (int i = 0; i < 64; i++) host_write();
        @(negedge clk);
        chk("R9", "not_rdy all written", longint'(st_not_rdy), 1);
        chk("R6", "blk_cnt before drain", longint'(blk_cnt), 2);
        tx_ready = 1;
        while (!xfer_done) @(negedge clk);
        tx_ready = 0;
        chk("R6", "blk_cnt after send", longint'(blk_cnt), 0);
        chk("R9", "scoreboard empty", longint'(exp_q.size()), 0);
        chk("R7", "core_acc after send", longint'(st_core_acc), 1);

        // abort in mid block
        ctl_write(1'b1, 1'b0);
        cnt_load(8'd2);
        rx_bytes(50);
        ctl_write(1'b0, 1'b1);
        exp_q.delete();
        @(negedge clk);
        chk("R11", "core_acc", longint'(st_core_acc), 1);
        chk("R11", "blk_cnt", longint'(blk_cnt), 0);
        chk("R11", "rx_ready", longint'(rx_ready), 0);
        chk("R11", "not_rdy", longint'(st_not_rdy), 1);
        chk("R11", "done", longint'(xfer_done), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule